// File: doc/BRIEF.md
# Self-Clocked Avionics Serial Word Receiver

The receiver takes the two legs of a bipolar return-to-zero line (one leg pulsed for a logic one, the other for a logic zero, both quiet between bits). Both legs pass through a two-flop synchroniser and are sampled at sixteen times the selected bit rate. Bit timing comes from the pulses themselves, so the receiver needs no separate bit clock. Each detected pulse counts as one bit. Thirty-two bits make a word. The first eight bits on the line carry the label with its most significant bit first, and the receiver turns them back to their natural order.

A word is accepted only when all of these hold: exactly thirty-two bits arrive, a long enough quiet period separates it from its neighbours, and it carries odd parity. An accepted word goes into a receive FIFO that a host drains one word per read strobe. An 8-bit control register holds the enable, the rate select and the FIFO level threshold. An 8-bit status view shows the FIFO flags and three sticky error bits. The interrupt output is high whenever any FIFO flag is high.

Top module: `avx_word_rx`

## Requirements
- R1: After reset, ctl_q is 0x00, stat_q is 0x05 (empty and level set), fifo_empty is 1, fifo_full is 0, irq is 1 and rd_data is 0.
- R2: A sample counts as a one when line_hi=1 and line_lo=0, and as a zero when line_lo=1 and line_hi=0. One bit is taken when the same polarity holds for at least 3 consecutive samples. Sampling runs at 16 samples per bit time behind a two-flop synchroniser.
- R3: Control bit 1 selects the sample period: 1 gives one sample every DIV_HI clocks, 0 gives one every DIV_LO clocks.
- R4: The first eight bits received go to word positions 7 down to 0, in that order. The remaining 24 bits go to positions 8 up to 31 in arrival order.
- R5: A 32-bit word with an even number of ones is discarded and sets sticky status bit 4.
- R6: A word that has fewer than 32 bits when 48 consecutive quiet samples (both legs low) are seen is discarded and sets sticky status bit 3.
- R7: After the 32nd bit, and after enabling, bits are refused until 48 consecutive quiet samples occur. Any bit that arrives before that is discarded and sets status bit 3.
- R8: Accepted words leave the FIFO in arrival order. A read strobe while the FIFO is not empty puts the oldest word on rd_data on the next clock.
- R9: A read strobe while the FIFO is empty leaves rd_data and all flags unchanged.
- R10: A word accepted while the FIFO is full is dropped and sets sticky status bit 5. The stored words are unchanged.
- R11: stat_q bit 0 is empty, bit 1 is full, and bit 2 is level (stored count >= control bits 7:4). irq is the OR of these three flags.
- R12: Writing the control register with bit 2 set clears status bits 3, 4 and 5. Bit 2 is not stored and reads back as 0.
- R13: With control bit 0 low, line activity is ignored: nothing is stored and no error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_hi | input | 1 | Line leg pulsed for a one |
| line_lo | input | 1 | Line leg pulsed for a zero |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value: bit0 enable, bit1 fast rate, bit2 clear errors, bits7:4 level threshold |
| ctl_q | output | 8 | Control register readback |
| stat_q | output | 8 | Status: bit0 empty, bit1 full, bit2 level, bit3 framing/gap error, bit4 parity error, bit5 overflow |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 32 | Last word read from the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_level | output | 1 | Stored count at or above threshold |
| irq | output | 1 | Interrupt, high while any FIFO flag is high |

## Verification
The bench builds the receiver with DIV_HI=2, DIV_LO=5 and DEPTH=4. This makes a fast bit time 32 clocks and a slow one 80 clocks, so whole words, short words, gap violations and both rates fit in a short run. A four-word FIFO makes the full flag, the level threshold and the overflow drop reachable after a handful of words. The empty-read hold is then checked right after draining.

// File: rtl/avx_rx_pkg.sv
// Shared constants and types for the serial word receiver.
// Assumes: the line format is fixed at 32-bit words with 16x oversampling.
package avx_rx_pkg;
    localparam int WORD_W    = 32;
    localparam int OVS       = 16;          // samples per bit time
    localparam int DET_RUN   = 3;           // samples needed to take a bit
    localparam int GAP_BITS  = 3;           // quiet bit times that close a word
    localparam int GAP_SMP   = GAP_BITS * OVS;
    localparam int LABEL_W   = 8;

    typedef enum logic [1:0] {
        SYM_QUIET = 2'd0,
        SYM_ONE   = 2'd1,
        SYM_ZERO  = 2'd2
    } sym_e;
endpackage

// File: rtl/avx_rx_sampler.sv
// Synchronises both line legs, generates the oversampling tick for the
// selected rate and turns pulses into bit strobes and a gap strobe.
// Assumes: DIV_HI and DIV_LO are at least 1; both legs high reads as quiet.
module avx_rx_sampler
    import avx_rx_pkg::*;
#(
    parameter int DIV_HI = 63,
    parameter int DIV_LO = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fast,
    input  logic line_hi,
    input  logic line_lo,
    output logic bit_stb,
    output logic bit_val,
    output logic gap_stb
);
    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW      = $clog2(DIV_MAX + 1);
    localparam int GW      = $clog2(GAP_SMP + 1);

    logic [1:0]    hi_s, lo_s;
    logic [CW-1:0] div_cnt, div_lim;
    logic          tick;
    sym_e          sym, run_sym;
    logic [1:0]    run_q, run_nxt;
    logic [GW-1:0] quiet_q;

    assign div_lim = fast ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign tick    = enable && (div_cnt >= div_lim);

    // Two-flop synchroniser on each leg.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_s <= '0;
            lo_s <= '0;
        end else begin
            hi_s <= {hi_s[0], line_hi};
            lo_s <= {lo_s[0], line_lo};
        end
    end

    // Divider producing one sample tick per period of the selected rate.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick) div_cnt <= '0;
        else                           div_cnt <= div_cnt + 1'b1;
    end

    // Classify the synchronised pair into a line symbol.
    always_comb begin
        if (hi_s[1] && !lo_s[1])      sym = SYM_ONE;
        else if (lo_s[1] && !hi_s[1]) sym = SYM_ZERO;
        else                          sym = SYM_QUIET;
    end

    // Length of the current pulse run, saturating at the detection count.
    always_comb begin
        if (sym == SYM_QUIET)                    run_nxt = '0;
        else if (sym == run_sym && run_q != '0)  run_nxt = (run_q == 2'(DET_RUN)) ? run_q : run_q + 1'b1;
        else                                     run_nxt = 2'd1;
    end

    // Run tracking and bit strobe on the sample that completes a run.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q   <= '0;
            run_sym <= SYM_QUIET;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (tick) begin
                run_q   <= run_nxt;
                run_sym <= sym;
                if (run_nxt == 2'(DET_RUN) && run_q != 2'(DET_RUN)) begin
                    bit_stb <= 1'b1;
                    bit_val <= (sym == SYM_ONE);
                end
            end
        end
    end

    // Quiet-sample counter and single gap strobe when it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            quiet_q <= '0;
            gap_stb <= 1'b0;
        end else begin
            gap_stb <= 1'b0;
            if (tick) begin
                if (sym != SYM_QUIET) begin
                    quiet_q <= '0;
                end else if (quiet_q != GW'(GAP_SMP)) begin
                    quiet_q <= quiet_q + 1'b1;
                    if (quiet_q == GW'(GAP_SMP - 1)) gap_stb <= 1'b1;
                end
            end
        end
    end

    AST_BIT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);  // R2
    AST_GAP_NOT_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_stb && gap_stb));  // R6
endmodule

// File: rtl/avx_rx_assembler.sv
// Places incoming bits into a 32-bit word (label reversed to natural order),
// enforces the quiet gap between words and checks odd parity.
// Assumes: bit_stb and gap_stb are single-cycle pulses and never coincide.
module avx_rx_assembler
    import avx_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              gap_stb,
    output logic              word_stb,
    output logic [WORD_W-1:0] word_q,
    output logic              par_err_stb,
    output logic              frm_err_stb
);
    localparam int BW = $clog2(WORD_W);

    logic              armed;
    logic [BW-1:0]     cnt;
    logic [BW-1:0]     pos;
    logic [WORD_W-1:0] word_nxt;

    // Bit position: label bits arrive most significant first.
    assign pos = (cnt < BW'(LABEL_W)) ? BW'(LABEL_W - 1) - cnt : cnt;

    // Word image including the bit being taken this cycle.
    always_comb begin
        word_nxt      = word_q;
        word_nxt[pos] = bit_val;
    end

    // Word collection, gap arming and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            cnt         <= '0;
            word_q      <= '0;
            word_stb    <= 1'b0;
            par_err_stb <= 1'b0;
            frm_err_stb <= 1'b0;
        end else begin
            word_stb    <= 1'b0;
            par_err_stb <= 1'b0;
            frm_err_stb <= 1'b0;
            if (!enable) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (bit_stb) begin
                if (!armed) begin
                    frm_err_stb <= 1'b1;
                end else begin
                    word_q <= word_nxt;
                    if (cnt == BW'(WORD_W - 1)) begin
                        cnt   <= '0;
                        armed <= 1'b0;
                        if (^word_nxt) word_stb    <= 1'b1;
                        else           par_err_stb <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else if (gap_stb) begin
                if (armed && cnt != '0) frm_err_stb <= 1'b1;
                cnt   <= '0;
                armed <= 1'b1;
            end
        end
    end

    AST_WORD_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> ^word_q);  // R5
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({word_stb, par_err_stb, frm_err_stb}) <= 1);  // R7
endmodule

// File: rtl/avx_rx_fifo.sv
// Receive FIFO: drops pushes when full, holds rd_data on empty reads.
// Assumes: DEPTH is a power of two and at least 2.
module avx_rx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = rd_en && !empty;

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= push_data;
    end

    // Pointers, occupancy and the read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) begin
                rptr    <= rptr + 1'b1;
                rd_data <= mem[rptr];
            end
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));  // R10
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !push) |=> ($stable(rd_data) && empty));  // R9
    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);  // R10
endmodule

// File: rtl/avx_word_rx.sv
// Top of the serial word receiver: control register, sticky errors,
// status view and interrupt around sampler, assembler and FIFO.
// Assumes: host accesses are synchronous to clk; the threshold is 4 bits wide.
module avx_word_rx
    import avx_rx_pkg::*;
#(
    parameter int DIV_HI = 63,
    parameter int DIV_LO = 500,
    parameter int DEPTH  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_hi,
    input  logic        line_lo,
    input  logic        ctl_we,
    input  logic [7:0]  ctl_wdata,
    output logic [7:0]  ctl_q,
    output logic [7:0]  stat_q,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        fifo_empty,
    output logic        fifo_full,
    output logic        fifo_level,
    output logic        irq
);
    localparam int CNTW = $clog2(DEPTH) + 1;

    logic              bit_stb, bit_val, gap_stb;
    logic              word_stb, par_err_stb, frm_err_stb;
    logic [WORD_W-1:0] word;
    logic [CNTW-1:0]   fifo_count;
    logic              clr, frm_err_q, par_err_q, ovf_q;

    assign clr = ctl_we && ctl_wdata[2];

    avx_rx_sampler #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_smp (
        .clk(clk), .rst_n(rst_n), .enable(ctl_q[0]), .fast(ctl_q[1]),
        .line_hi(line_hi), .line_lo(line_lo),
        .bit_stb(bit_stb), .bit_val(bit_val), .gap_stb(gap_stb)
    );

    avx_rx_assembler u_asm (
        .clk(clk), .rst_n(rst_n), .enable(ctl_q[0]),
        .bit_stb(bit_stb), .bit_val(bit_val), .gap_stb(gap_stb),
        .word_stb(word_stb), .word_q(word),
        .par_err_stb(par_err_stb), .frm_err_stb(frm_err_stb)
    );

    avx_rx_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(word_stb), .push_data(word),
        .rd_en(rd_en), .rd_data(rd_data), .count(fifo_count),
        .empty(fifo_empty), .full(fifo_full)
    );

    // Control register; the clear bit is a strobe and is not kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata & 8'hFB;
    end

    // Sticky error bits, cleared by a control write with the clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frm_err_q <= 1'b0;
            par_err_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (frm_err_stb)           frm_err_q <= 1'b1;
            if (par_err_stb)           par_err_q <= 1'b1;
            if (word_stb && fifo_full) ovf_q     <= 1'b1;
        end
    end

    assign fifo_level = (32'(fifo_count) >= 32'(ctl_q[7:4]));
    assign irq        = fifo_empty | fifo_full | fifo_level;
    assign stat_q     = {2'b00, ovf_q, par_err_q, frm_err_q, fifo_level, fifo_full, fifo_empty};

    AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && fifo_full && !clr) |=> ovf_q);  // R10
    AST_ERRORS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);  // R12
    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[0] && !$past(ctl_q[0])) |-> !word_stb);  // R13
endmodule

// File: tb/avx_word_rx_test.sv
// Self-checking bench for the serial word receiver.
module avx_word_rx_test;
    localparam int DIV_HI = 2;
    localparam int DIV_LO = 5;
    localparam int DEPTH  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_hi = 1'b0, line_lo = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_q, stat_q;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        fifo_empty, fifo_full, fifo_level, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    avx_word_rx #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .stat_q(stat_q),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_level(fifo_level), .irq(irq)
    );

    // Vector: {outcome[1:0] (0 stored, 1 framing, 2 parity), flip, nbits[5:0], word[31:0]}
    localparam logic [40:0] VEC [7] = '{
        {2'd0, 1'b0, 6'd32, 32'h0000_00A5},   // R4 label order
        {2'd0, 1'b0, 6'd32, 32'h1234_5681},
        {2'd2, 1'b1, 6'd32, 32'h0555_5501},   // R5 bad parity
        {2'd0, 1'b0, 6'd32, 32'h7FFF_FF00},
        {2'd1, 1'b0, 6'd10, 32'h0000_0033},   // R6 short word
        {2'd1, 1'b0, 6'd31, 32'h0F0F_0F0F},   // R6 one bit short
        {2'd0, 1'b0, 6'd32, 32'h2AAA_AAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] odd_fix(input logic [31:0] w);
        return {~(^w[30:0]), w[30:0]};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_bits(input int nbits, input int div);
        line_hi = 1'b0; line_lo = 1'b0;
        idle(16 * nbits * div);
    endtask

    task automatic send(input logic [31:0] w, input int nbits, input int div);
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = (i < 8) ? 7 - i : i;
            line_hi = w[idx];
            line_lo = ~w[idx];
            idle(8 * div);
            line_hi = 1'b0; line_lo = 1'b0;
            idle(8 * div);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic rd_pulse;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [31:0] saved;
        logic [31:0] burst [5];

        idle(4);
        // R1 reset state
        chk("R1 ctl", 32'(ctl_q), 32'h00);
        chk("R1 stat", 32'(stat_q), 32'h05);
        chk("R1 empty/full/irq", {29'b0, fifo_empty, fifo_full, irq}, 32'b101);
        chk("R1 rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        idle(2);

        wr_ctl(8'h03);                 // enable, fast, threshold 0
        quiet_bits(4, DIV_HI);         // R7 arm after enable

        // Table walk: R2 R4 R5 R6 R8 R12
        for (int v = 0; v < 7; v++) begin
            logic [1:0] outc;
            outc = VEC[v][40:39];
            w = odd_fix(VEC[v][31:0]);
            if (VEC[v][38]) w[31] = ~w[31];
            send(w, int'(VEC[v][37:32]), DIV_HI);
            quiet_bits(4, DIV_HI);
            if (outc == 2'd0) begin
                chk("R2 word stored", 32'(fifo_empty), 32'd0);
                rd_pulse();
                chk("R4 R8 read word", rd_data, w);
                chk("R8 drained", 32'(fifo_empty), 32'd1);
            end else begin
                chk("R5 R6 word discarded", 32'(fifo_empty), 32'd1);
            end
            chk("R5 R6 error bits", 32'(stat_q[5:3]),
                (outc == 2'd1) ? 32'b001 : (outc == 2'd2) ? 32'b010 : 32'b000);
            wr_ctl(8'h07);
            chk("R12 clear bit reads 0", 32'(ctl_q), 32'h03);
            chk("R12 errors cleared", 32'(stat_q[5:3]), 32'h0);
        end

        // R9 empty read holds data
        saved = rd_data;
        rd_pulse();
        chk("R9 rd_data held", rd_data, saved);
        chk("R9 flags held", 32'(stat_q), 32'h05);

        // R7 gap violation: second word follows after one bit time only
        w = odd_fix(32'h00C3_3C81);
        send(w, 32, DIV_HI);
        quiet_bits(1, DIV_HI);
        send(odd_fix(32'h0101_0101), 32, DIV_HI);
        quiet_bits(4, DIV_HI);
        chk("R7 gap error", 32'(stat_q[3]), 32'd1);
        rd_pulse();
        chk("R7 first word kept", rd_data, w);
        chk("R7 second word dropped", 32'(fifo_empty), 32'd1);
        wr_ctl(8'h07);

        // R10 R11 level, full, overflow with threshold 2
        wr_ctl(8'h23);
        for (int k = 0; k < 5; k++) begin
            burst[k] = odd_fix(32'h0100_0010 * (k + 1) + 32'h0000_00F0);
            send(burst[k], 32, DIV_HI);
            quiet_bits(4, DIV_HI);
            if (k == 0) begin
                chk("R11 below level", 32'(stat_q[2:0]), 32'b000);
                chk("R11 irq low", 32'(irq), 32'd0);
            end
            if (k == 1) chk("R11 at level", 32'(stat_q[2:0]), 32'b100);
            if (k == 3) chk("R11 full", 32'(stat_q[2:0]), 32'b110);
        end
        chk("R10 overflow bit", 32'(stat_q[5]), 32'd1);
        chk("R11 irq high", 32'(irq), 32'd1);
        for (int k = 0; k < 4; k++) begin
            rd_pulse();
            chk("R8 R10 order after overflow", rd_data, burst[k]);
        end
        chk("R10 fifo empty after drain", 32'(fifo_empty), 32'd1);
        wr_ctl(8'h07);

        // R3 slow rate
        wr_ctl(8'h01);
        quiet_bits(4, DIV_LO);
        w = odd_fix(32'h5A5A_A5C3);
        send(w, 32, DIV_LO);
        quiet_bits(4, DIV_LO);
        chk("R3 slow word stored", 32'(fifo_empty), 32'd0);
        rd_pulse();
        chk("R3 slow word", rd_data, w);

        // R13 disabled ignores the line
        wr_ctl(8'h02);
        send(odd_fix(32'h0000_0777), 32, DIV_HI);
        quiet_bits(4, DIV_HI);
        chk("R13 nothing stored", 32'(stat_q), 32'h05);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule